// File: doc/BRIEF.md
# Bit-Serial CRC Generator and Checker

This block computes a cyclic redundancy remainder one bit per clock, using modulo-2 long division in which XOR stands in for subtraction. It holds one shift register and two fixed generators: a short one, x^5 + x^2 + 1 (pattern 100101), for small control packets, and a long one, x^16 + x^15 + x^2 + 1 (pattern 11000000000000101), for payload packets. The generator is chosen when a packet opens. During the packet it stays fixed.

To protect a message, pulse `start_i` and feed the message most significant bit first with `drain_i` low. Then raise `drain_i` for n valid cycles to stream the n-bit remainder out, most significant bit first. The message followed by that remainder is the codeword. It equals the message shifted left by n places, XORed with the remainder of that shifted value divided by the generator. To check a received codeword, feed all of it, remainder included, as data. `zero_o` then shows whether the final remainder is zero.

Top module: `crc_serial_engine`

## Requirements
- R1: After a synchronous active-low reset, the register is zero, `zero_o` is 1, `rem_vld_o` is 0 and `rem_bit_o` is 0.
- R2: A cycle with `start_i`=1 clears the register and latches `poly_sel_i` (0 selects x^5+x^2+1, 1 selects x^16+x^15+x^2+1). Any `bit_vld_i` in that same cycle is discarded.
- R3: Each cycle with `bit_vld_i`=1, `drain_i`=0 and `start_i`=0 takes in one message bit. After the message, the register holds the remainder of the message times x^n, divided modulo 2 by the selected generator.
- R4: With the short generator, the message 10100101 leaves the remainder 01110, which gives the codeword 1010010101110.
- R5: With the long generator, draining after any message yields the 16-bit remainder of the message times x^16 modulo x^16+x^15+x^2+1.
- R6: Each cycle with `bit_vld_i`=1, `drain_i`=1 and `start_i`=0 sends out the current remainder MSB. On the next cycle that bit appears on `rem_bit_o` with `rem_vld_o`=1, and the register shifts toward its MSB with a zero fill. `bit_i` has no effect during drain. In every other cycle, `rem_vld_o` is 0 on the next cycle.
- R7: A cycle with `bit_vld_i`=0 and `start_i`=0 leaves the register and `zero_o` unchanged.
- R8: Feeding a whole error-free codeword as data leaves `zero_o`=1. Flipping any single bit of it leaves `zero_o`=0.
- R9: A change of `poly_sel_i` after `start_i` has no effect on the division until the next `start_i`.
- R10: `zero_o` is 1 exactly when the register bits of the active width are all zero. While the short generator is selected, the bits above width 5 stay zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Clears the register and latches the generator choice |
| poly_sel_i | input | 1 | Generator choice: 0 short (5-bit), 1 long (16-bit) |
| bit_vld_i | input | 1 | Qualifies this cycle as a shift step |
| bit_i | input | 1 | Serial message or codeword bit, MSB first |
| drain_i | input | 1 | 1: shift the remainder out; 0: take in `bit_i` |
| rem_bit_o | output | 1 | Serial remainder bit, MSB first |
| rem_vld_o | output | 1 | `rem_bit_o` carries a remainder bit |
| zero_o | output | 1 | Register is all zero |

## Verification
The bench builds the block with its default widths of 5 and 16 and the two default generators. This lets it use the known 8-bit answer for the short generator and a 24-bit message for the long generator, which moves the feedback through all sixteen stages. Because the two widths differ, a generator switch in mid-packet and the masking of the upper register bits in short mode both show up at the ports. A behavioural long-division model predicts the remainder stream and the zero flag on every clock. The tests cover idle gaps, a start that coincides with a valid bit, and corrupted codewords.

// File: rtl/crc_serial_pkg.sv
// Package: shared types for the serial CRC engine.
// Assumes: the generator choice is a single bit, 0 for the short divisor.
package crc_serial_pkg;

    typedef enum logic {
        GEN_SHORT = 1'b0,
        GEN_LONG  = 1'b1
    } gen_sel_e;

    // Larger of two widths, used to size the shared register.
    function automatic int width_max(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/crc_gen_select.sv
// Module: latches the generator choice at packet start and presents the
// matching feedback taps, active-width mask and MSB one-hot.
// Assumes: SHORT_W and LONG_W do not exceed REG_W; taps exclude the x^n term.
module crc_gen_select
    import crc_serial_pkg::*;
#(
    parameter int               REG_W      = 16,
    parameter int               SHORT_W    = 5,
    parameter int               LONG_W     = 16,
    parameter logic [REG_W-1:0] SHORT_TAPS = 16'h0005,
    parameter logic [REG_W-1:0] LONG_TAPS  = 16'h8005
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  gen_sel_e         sel_i,
    output gen_sel_e         sel_o,
    output logic [REG_W-1:0] taps_o,
    output logic [REG_W-1:0] mask_o,
    output logic [REG_W-1:0] top_o
);

    gen_sel_e         sel_q;
    logic [REG_W-1:0] short_mask, long_mask, short_top, long_top;

    // Build per-bit width masks and MSB markers for both divisors.
    for (genvar i = 0; i < REG_W; i++) begin : g_bit
        assign short_mask[i] = (i < SHORT_W);
        assign long_mask[i]  = (i < LONG_W);
        assign short_top[i]  = (i == SHORT_W - 1);
        assign long_top[i]   = (i == LONG_W - 1);
    end

    // Capture the divisor choice only when a packet opens.
    always_ff @(posedge clk) begin
        if (!rst_n)       sel_q <= GEN_SHORT;
        else if (start_i) sel_q <= sel_i;
    end

    // Present the shape of the latched divisor.
    always_comb begin
        if (sel_q == GEN_LONG) begin
            taps_o = LONG_TAPS;
            mask_o = long_mask;
            top_o  = long_top;
        end else begin
            taps_o = SHORT_TAPS;
            mask_o = short_mask;
            top_o  = short_top;
        end
    end

    assign sel_o = sel_q;

    // R9
    sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !start_i |=> $stable(sel_q));

endmodule

// File: rtl/crc_shift_reg.sv
// Module: the division register. It clears on start, takes one message bit
// per step with feedback at the divisor taps, or shifts out toward the MSB
// with zero fill when draining.
// Assumes: mask_i, top_i and taps_i describe one consistent divisor.
module crc_shift_reg #(
    parameter int REG_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             step_i,
    input  logic             drain_i,
    input  logic             bit_i,
    input  logic [REG_W-1:0] taps_i,
    input  logic [REG_W-1:0] mask_i,
    input  logic [REG_W-1:0] top_i,
    output logic [REG_W-1:0] crc_o,
    output logic             msb_o
);

    logic [REG_W-1:0] crc_q, crc_d, shifted;
    logic             feedback;

    assign msb_o    = |(crc_q & top_i);
    assign shifted  = (crc_q << 1) & mask_i;
    assign feedback = msb_o ^ bit_i;

    // Next register value for a single step, either divide or drain.
    always_comb begin
        if (drain_i)       crc_d = shifted;
        else if (feedback) crc_d = shifted ^ (taps_i & mask_i);
        else               crc_d = shifted;
    end

    // Register update: clear has priority, steps advance, idle holds.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) crc_q <= '0;
        else if (step_i)       crc_q <= crc_d;
    end

    assign crc_o = crc_q;

    // R2
    clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (crc_q == '0));

    // R7
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear_i && !step_i) |=> $stable(crc_q));

endmodule

// File: rtl/crc_emit.sv
// Module: registers the serial remainder output, one bit per drain step.
// Assumes: fire_i is already qualified by valid, drain and no start.
module crc_emit (
    input  logic clk,
    input  logic rst_n,
    input  logic fire_i,
    input  logic msb_i,
    output logic rem_bit_o,
    output logic rem_vld_o
);

    // Launch the current MSB with its valid flag, zero when idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_bit_o <= 1'b0;
            rem_vld_o <= 1'b0;
        end else begin
            rem_bit_o <= fire_i & msb_i;
            rem_vld_o <= fire_i;
        end
    end

    // R6
    emit_vld_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fire_i |=> rem_vld_o);

    // R6
    emit_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fire_i |=> (!rem_vld_o && !rem_bit_o));

endmodule

// File: rtl/crc_serial_engine.sv
// Module: top of the bit-serial CRC generator/checker with two fixed divisors.
// Assumes: the message arrives MSB first; the register is preset to zero.
module crc_serial_engine
    import crc_serial_pkg::*;
#(
    parameter int          SHORT_W    = 5,
    parameter int          LONG_W     = 16,
    parameter logic [31:0] SHORT_POLY = 32'h0000_0005,
    parameter logic [31:0] LONG_POLY  = 32'h0000_8005
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic poly_sel_i,
    input  logic bit_vld_i,
    input  logic bit_i,
    input  logic drain_i,
    output logic rem_bit_o,
    output logic rem_vld_o,
    output logic zero_o
);

    localparam int REG_W = width_max(SHORT_W, LONG_W);

    gen_sel_e         sel;
    logic [REG_W-1:0] taps, mask, top, crc;
    logic             msb, step, fire;

    assign step = bit_vld_i & ~start_i;
    assign fire = step & drain_i;

    crc_gen_select #(
        .REG_W      (REG_W),
        .SHORT_W    (SHORT_W),
        .LONG_W     (LONG_W),
        .SHORT_TAPS (SHORT_POLY[REG_W-1:0]),
        .LONG_TAPS  (LONG_POLY[REG_W-1:0])
    ) i_sel (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_i),
        .sel_i   (gen_sel_e'(poly_sel_i)),
        .sel_o   (sel),
        .taps_o  (taps),
        .mask_o  (mask),
        .top_o   (top)
    );

    crc_shift_reg #(.REG_W(REG_W)) i_reg (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (start_i),
        .step_i  (step),
        .drain_i (drain_i),
        .bit_i   (bit_i),
        .taps_i  (taps),
        .mask_i  (mask),
        .top_i   (top),
        .crc_o   (crc),
        .msb_o   (msb)
    );

    crc_emit i_emit (
        .clk       (clk),
        .rst_n     (rst_n),
        .fire_i    (fire),
        .msb_i     (msb),
        .rem_bit_o (rem_bit_o),
        .rem_vld_o (rem_vld_o)
    );

    assign zero_o = (crc == '0);

    // R10
    short_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == GEN_SHORT) |-> (crc[REG_W-1:SHORT_W] == '0));

    // R1
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (zero_o && !rem_vld_o));

endmodule

// File: tb/test_crc_serial_engine.sv
module test_crc_serial_engine;

    logic clk = 1'b0;
    logic rst_n, start_i, poly_sel_i, bit_vld_i, bit_i, drain_i;
    logic rem_bit_o, rem_vld_o, zero_o;

    int n_run = 0;
    int n_fail = 0;
    bit finished = 0;

    // model state
    bit m_msg[$];
    int m_w = 5, m_g = 'h25, m_k = 0;
    bit m_rv = 0, m_rb = 0;
    bit cap[$];

    always #10 clk = ~clk;

    crc_serial_engine i_crc_serial_engine (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .poly_sel_i(poly_sel_i),
        .bit_vld_i(bit_vld_i), .bit_i(bit_i), .drain_i(drain_i),
        .rem_bit_o(rem_bit_o), .rem_vld_o(rem_vld_o), .zero_o(zero_o));

    function automatic int rem_of(input bit q[$], input int w, input int g);
        int acc = 0;
        foreach (q[i]) begin
            acc = (acc << 1) | int'(q[i]);
            if ((acc >> w) & 1) acc = acc ^ g;
        end
        for (int i = 0; i < w; i++) begin
            acc = acc << 1;
            if ((acc >> w) & 1) acc = acc ^ g;
        end
        return acc;
    endfunction

    function automatic int exp_reg();
        int mask = (1 << m_w) - 1;
        return (rem_of(m_msg, m_w, m_g) << m_k) & mask;
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // One clock: drive at negedge, update model at posedge, compare at next negedge.
    task automatic step(input bit s, input bit v, input bit b, input bit d, input bit sel);
        int r;
        start_i = s; bit_vld_i = v; bit_i = b; drain_i = d; poly_sel_i = sel;
        @(posedge clk);
        m_rv = 0; m_rb = 0;
        if (!rst_n) begin
            m_msg.delete(); m_k = 0; m_w = 5; m_g = 'h25;
        end else if (s) begin
            m_msg.delete(); m_k = 0;
            m_w = sel ? 16 : 5; m_g = sel ? 'h18005 : 'h25;
        end else if (v && d) begin
            r = rem_of(m_msg, m_w, m_g);
            m_rv = 1;
            m_rb = (m_k < m_w) ? bit'((r >> (m_w - 1 - m_k)) & 1) : 1'b0;
            m_k++;
        end else if (v) begin
            m_msg.push_back(b);
        end
        @(negedge clk);
        check(zero_o == (exp_reg() == 0), "R10 zero_o", zero_o, exp_reg() == 0);
        check(rem_vld_o == m_rv, "R6 rem_vld_o", rem_vld_o, m_rv);
        check(rem_bit_o == m_rb, "R6 rem_bit_o", rem_bit_o, m_rb);
        if (rem_vld_o) cap.push_back(rem_bit_o);
    endtask

    task automatic feed(input bit q[$], input bit sel);
        foreach (q[i]) step(0, 1, q[i], 0, sel);
    endtask

    task automatic drain(input int n, input bit sel);
        cap.delete();
        for (int i = 0; i < n; i++) step(0, 1, (i % 2 == 0), 1, sel);
    endtask

    function automatic int cap_val();
        int v = 0;
        foreach (cap[i]) v = (v << 1) | int'(cap[i]);
        return v;
    endfunction

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_fail++; n_run++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin : main
        bit msg[$];
        bit cw[$];
        int r;
        rst_n = 0; start_i = 0; poly_sel_i = 0; bit_vld_i = 0; bit_i = 0; drain_i = 0;
        @(negedge clk);
        step(0, 0, 0, 0, 0);
        step(0, 1, 1, 0, 0);
        // R1 reset state
        check(zero_o == 1 && rem_vld_o == 0 && rem_bit_o == 0, "R1 reset",
              {zero_o, rem_vld_o, rem_bit_o}, 3'b100);
        rst_n = 1;

        // R4 known answer, short divisor, with idle gaps (R7)
        msg = '{1,0,1,0,0,1,0,1};
        step(1, 0, 0, 0, 0);
        foreach (msg[i]) begin
            step(0, 1, msg[i], 0, 0);
            if (i == 3) begin
                step(0, 0, 1, 0, 0);
                step(0, 0, 0, 1, 1);
            end
        end
        drain(5, 0);
        check(cap_val() == 5'b01110, "R4 short remainder", cap_val(), 5'b01110);
        check(zero_o == 1, "R6 drained register empty", zero_o, 1);
        drain(2, 0);
        check(cap_val() == 0, "R6 drain past width gives zeros", cap_val(), 0);

        // R8 check mode: clean and corrupted codewords, short
        cw = '{1,0,1,0,0,1,0,1,0,1,1,1,0};
        step(1, 0, 0, 0, 0);
        feed(cw, 0);
        check(zero_o == 1, "R8 short codeword clean", zero_o, 1);
        for (int j = 0; j < 13; j += 4) begin
            bit bad[$];
            bad = cw;
            bad[j] = ~bad[j];
            step(1, 0, 0, 0, 0);
            feed(bad, 0);
            check(zero_o == 0, "R8 short codeword flipped", zero_o, 0);
        end

        // R2 start coinciding with a valid bit discards the bit
        step(0, 1, 1, 0, 0);
        step(1, 1, 1, 0, 0);
        check(zero_o == 1, "R2 start clears, bit discarded", zero_o, 1);
        feed(msg, 0);
        drain(5, 0);
        check(cap_val() == 5'b01110, "R2 after coincident start", cap_val(), 5'b01110);

        // R3 R5 long divisor, 24-bit message
        msg.delete();
        for (int i = 23; i >= 0; i--) msg.push_back(bit'((32'hC3A51E >> i) & 1));
        step(1, 0, 0, 0, 1);
        feed(msg, 1);
        r = rem_of(msg, 16, 'h18005);
        drain(16, 1);
        check(cap_val() == r, "R5 long remainder", cap_val(), r);
        cw = msg;
        for (int i = 15; i >= 0; i--) cw.push_back(bit'((r >> i) & 1));
        step(1, 0, 0, 0, 1);
        feed(cw, 1);
        check(zero_o == 1, "R8 long codeword clean", zero_o, 1);
        cw[30] = ~cw[30];
        step(1, 0, 0, 0, 1);
        feed(cw, 1);
        check(zero_o == 0, "R8 long codeword flipped", zero_o, 0);

        // R3 another short message, all ones
        msg = '{1,1,1,1,1,1,1,1,1,1};
        step(1, 0, 0, 0, 0);
        feed(msg, 0);
        r = rem_of(msg, 5, 'h25);
        drain(5, 0);
        check(cap_val() == r, "R3 short all-ones", cap_val(), r);

        // R9 select toggled mid-packet: short stays in force
        msg = '{1,0,1,0,0,1,0,1};
        step(1, 0, 0, 0, 0);
        foreach (msg[i]) step(0, 1, msg[i], 0, (i % 2 == 1));
        drain(5, 1);
        check(cap_val() == 5'b01110, "R9 select ignored mid-packet", cap_val(), 5'b01110);

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule